// File: doc/BRIEF.md
# Relocatable I/O Window Decoder

This block holds the configuration registers of a power-management function that owns two I/O windows which software may move: a 128-byte power-management window and a 16-byte SMBus window. Software places each window by writing a base register and opens it by setting an enable bit held in a separate configuration byte. Configuration accesses are 32-bit dword accesses with per-byte lane enables, so a write may update any subset of the bytes of a register.

Each I/O address presented to the block is compared against both windows. When the address falls inside an enabled window, the matching hit output rises and the offset output carries the address bits below the window's alignment boundary. The registers that live behind each window are handled elsewhere; this block only decodes, masks and gates. When both windows claim the same address, the power-management window wins.

Top module: `iowin_decode`

## Requirements
- R1: While rst_ni is low, and after it is released, the dword at configuration offset 0x48 and the dword at 0x90 both read 0x00000001, the dwords at 0x40 and 0xD0 read 0x00000000, and neither hit output is high.
- R2: The power-management base dword (offset 0x48) stores only bits 15:7; it always reads with bit 0 equal to 1 and every other bit outside 15:7 equal to 0, whatever was written.
- R3: The SMBus base dword (offset 0x90) stores only bits 15:4; it always reads with bit 0 equal to 1 and every other bit outside 15:4 equal to 0.
- R4: A write updates only the byte lanes whose cfg_be_i bit is set (lane n covers data bits 8n+7:8n); the bits of lanes not enabled keep their value, and the fixed-bit masking of R2 and R3 applies after the merge. A write with no lane enabled changes nothing.
- R5: Configuration byte 0x41 (dword 0x40, lane 1, read bits 15:8) is a full 8-bit register; the power-management window decodes only while its bit 7 is 1. Other bytes of dword 0x40 read 0.
- R6: Configuration byte 0xD2 (dword 0xD0, lane 2, read bits 23:16) keeps only the low 4 bits of a write, the upper 4 reading 0; the SMBus window decodes only while its bit 0 is 1.
- R7: pm_hit_o is high when the power-management window is enabled and io_addr_i[15:7] equals the stored base bits 15:7; pm_off_o then equals io_addr_i[6:0].
- R8: The SMBus window matches when it is enabled and io_addr_i[15:4] equals the stored base bits 15:4; smb_off_o equals io_addr_i[3:0].
- R9: pm_hit_o and smb_hit_o are never high together; on an address inside both enabled windows only pm_hit_o is high.
- R10: Dwords other than 0x40, 0x48, 0x90 and 0xD0 read 0 and writes to them have no effect on any register. cfg_rdata_o and the hit outputs follow their inputs in the same cycle; a write takes effect at the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 8 | Configuration byte address; bits 7:2 select the dword |
| cfg_be_i | input | 4 | Byte lane enables for writes |
| cfg_wdata_i | input | 32 | Configuration write data |
| cfg_rdata_o | output | 32 | Configuration read data of the addressed dword |
| io_addr_i | input | 16 | I/O address to decode |
| pm_hit_o | output | 1 | Address falls in the enabled power-management window |
| pm_off_o | output | 7 | Offset inside the power-management window |
| smb_hit_o | output | 1 | Address falls in the enabled SMBus window and not in the power-management window |
| smb_off_o | output | 4 | Offset inside the SMBus window |

## Verification
The hardest situation to reach is an I/O address claimed by both windows, which needs both bases placed so that the 16-byte window sits inside the 128-byte one and both enable bytes set through their own lanes. The bench programs the SMBus base to 0x1010 and the power-management base to 0x1000, opens both, and probes an address in the overlap, then closes the power-management window to show the SMBus window was matching underneath. Partial-lane writes are reached by writing single lanes after a full write, so that the merged result differs from both the old and the new data.

// File: rtl/iowin_pkg.sv
package iowin_pkg;

  localparam int unsigned CFG_AW   = 8;
  localparam int unsigned CFG_DW   = 32;
  localparam int unsigned CFG_LANES = CFG_DW / 8;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_PM_BASE,
    SEL_PM_EN,
    SEL_SMB_BASE,
    SEL_SMB_EN
  } cfg_sel_e;

  function automatic logic [CFG_AW-3:0] dword_of(input logic [CFG_AW-1:0] a);
    return a[CFG_AW-1:2];
  endfunction

endpackage

// File: rtl/cfg_base_reg.sv
module cfg_base_reg
  import iowin_pkg::*;
#(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned ALIGN = 7,
  localparam int unsigned FW   = IO_AW - ALIGN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_LANES-1:0] be_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_DW-1:0] rdata_o,
  output logic [FW-1:0]     base_o
);

  logic [FW-1:0] base_q;
  logic          unused_in;

  assign unused_in = ^{be_i, wdata_i};

  // Merge per lane, then only the writable field is kept.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
    end else if (we_i) begin
      for (int i = 0; i < int'(FW); i++) begin
        if (be_i[(i + ALIGN) / 8]) base_q[i] <= wdata_i[i + ALIGN];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[IO_AW-1:ALIGN] = base_q;
    rdata_o[0] = 1'b1;
  end

  assign base_o = base_q;

endmodule

// File: rtl/cfg_en_reg.sv
module cfg_en_reg
  import iowin_pkg::*;
#(
  parameter int unsigned LANE = 1,
  parameter logic [7:0]  KEEP = 8'hff
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CFG_LANES-1:0] be_i,
  input  logic [CFG_DW-1:0] wdata_i,
  output logic [CFG_DW-1:0] rdata_o,
  output logic [7:0]        val_o
);

  logic [7:0] q;
  logic       unused_in;

  assign unused_in = ^{be_i, wdata_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                q <= '0;
    else if (we_i && be_i[LANE]) q <= wdata_i[LANE*8 +: 8] & KEEP;
  end

  always_comb begin
    rdata_o = '0;
    rdata_o[LANE*8 +: 8] = q;
  end

  assign val_o = q;

endmodule

// File: rtl/win_match.sv
module win_match #(
  parameter int unsigned IO_AW = 16,
  parameter int unsigned ALIGN = 7,
  localparam int unsigned FW   = IO_AW - ALIGN
) (
  input  logic             en_i,
  input  logic [FW-1:0]    base_i,
  input  logic [IO_AW-1:0] addr_i,
  output logic             hit_o,
  output logic [ALIGN-1:0] off_o
);

  assign hit_o = en_i && (addr_i[IO_AW-1:ALIGN] == base_i);
  assign off_o = addr_i[ALIGN-1:0];

endmodule

// File: rtl/iowin_decode.sv
module iowin_decode
  import iowin_pkg::*;
#(
  parameter int unsigned IO_AW        = 16,
  parameter int unsigned PM_ALIGN     = 7,
  parameter int unsigned SMB_ALIGN    = 4,
  parameter logic [7:0]  PM_BASE_OFF  = 8'h48,
  parameter logic [7:0]  PM_EN_OFF    = 8'h41,
  parameter int unsigned PM_EN_BIT    = 7,
  parameter logic [7:0]  SMB_BASE_OFF = 8'h90,
  parameter logic [7:0]  SMB_EN_OFF   = 8'hd2,
  parameter int unsigned SMB_EN_BIT   = 0,
  parameter logic [7:0]  SMB_EN_KEEP  = 8'h0f
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cfg_we_i,
  input  logic [CFG_AW-1:0]    cfg_addr_i,
  input  logic [CFG_LANES-1:0] cfg_be_i,
  input  logic [CFG_DW-1:0]    cfg_wdata_i,
  output logic [CFG_DW-1:0]    cfg_rdata_o,
  input  logic [IO_AW-1:0]     io_addr_i,
  output logic                 pm_hit_o,
  output logic [PM_ALIGN-1:0]  pm_off_o,
  output logic                 smb_hit_o,
  output logic [SMB_ALIGN-1:0] smb_off_o
);

  localparam int unsigned PM_FW  = IO_AW - PM_ALIGN;
  localparam int unsigned SMB_FW = IO_AW - SMB_ALIGN;

  logic [CFG_AW-3:0] dw;
  logic sel_pm_base, sel_pm_en, sel_smb_base, sel_smb_en;
  logic [CFG_DW-1:0] pm_base_rd, pm_en_rd, smb_base_rd, smb_en_rd;
  logic [PM_FW-1:0]  pm_base;
  logic [SMB_FW-1:0] smb_base;
  logic [7:0] pm_en_val, smb_en_val;
  logic pm_raw, smb_raw;
  logic unused_bits;

  assign dw           = dword_of(cfg_addr_i);
  assign sel_pm_base  = dw == dword_of(PM_BASE_OFF);
  assign sel_pm_en    = dw == dword_of(PM_EN_OFF);
  assign sel_smb_base = dw == dword_of(SMB_BASE_OFF);
  assign sel_smb_en   = dw == dword_of(SMB_EN_OFF);

  cfg_base_reg #(.IO_AW(IO_AW), .ALIGN(PM_ALIGN)) u_pm_base (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && sel_pm_base), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .rdata_o(pm_base_rd), .base_o(pm_base)
  );

  cfg_base_reg #(.IO_AW(IO_AW), .ALIGN(SMB_ALIGN)) u_smb_base (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && sel_smb_base), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .rdata_o(smb_base_rd), .base_o(smb_base)
  );

  cfg_en_reg #(.LANE(int'(PM_EN_OFF[1:0])), .KEEP(8'hff)) u_pm_en (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && sel_pm_en), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .rdata_o(pm_en_rd), .val_o(pm_en_val)
  );

  cfg_en_reg #(.LANE(int'(SMB_EN_OFF[1:0])), .KEEP(SMB_EN_KEEP)) u_smb_en (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i && sel_smb_en), .be_i(cfg_be_i), .wdata_i(cfg_wdata_i),
    .rdata_o(smb_en_rd), .val_o(smb_en_val)
  );

  // OR-mux so that registers sharing a dword merge cleanly.
  always_comb begin
    cfg_rdata_o = '0;
    if (sel_pm_base)  cfg_rdata_o |= pm_base_rd;
    if (sel_pm_en)    cfg_rdata_o |= pm_en_rd;
    if (sel_smb_base) cfg_rdata_o |= smb_base_rd;
    if (sel_smb_en)   cfg_rdata_o |= smb_en_rd;
  end

  win_match #(.IO_AW(IO_AW), .ALIGN(PM_ALIGN)) u_pm_match (
    .en_i(pm_en_val[PM_EN_BIT]), .base_i(pm_base), .addr_i(io_addr_i),
    .hit_o(pm_raw), .off_o(pm_off_o)
  );

  win_match #(.IO_AW(IO_AW), .ALIGN(SMB_ALIGN)) u_smb_match (
    .en_i(smb_en_val[SMB_EN_BIT]), .base_i(smb_base), .addr_i(io_addr_i),
    .hit_o(smb_raw), .off_o(smb_off_o)
  );

  // Power-management window wins on overlap.
  assign pm_hit_o  = pm_raw;
  assign smb_hit_o = smb_raw && !pm_raw;

  assign unused_bits = ^{cfg_addr_i[1:0], pm_en_val, smb_en_val};

endmodule

// File: rtl/iowin_decode_chk.sv
module iowin_decode_chk
  import iowin_pkg::*;
#(
  parameter int unsigned IO_AW        = 16,
  parameter int unsigned PM_ALIGN     = 7,
  parameter int unsigned SMB_ALIGN    = 4,
  parameter logic [7:0]  PM_BASE_OFF  = 8'h48,
  parameter logic [7:0]  PM_EN_OFF    = 8'h41,
  parameter logic [7:0]  SMB_BASE_OFF = 8'h90,
  parameter logic [7:0]  SMB_EN_OFF   = 8'hd2
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [CFG_AW-1:0]    cfg_addr_i,
  input logic [CFG_DW-1:0]    cfg_rdata_o,
  input logic [IO_AW-1:0]     io_addr_i,
  input logic                 pm_hit_o,
  input logic [PM_ALIGN-1:0]  pm_off_o,
  input logic                 smb_hit_o,
  input logic [SMB_ALIGN-1:0] smb_off_o
);

  logic at_pm_base, at_smb_base, at_mapped;

  assign at_pm_base  = cfg_addr_i[CFG_AW-1:2] == PM_BASE_OFF[CFG_AW-1:2];
  assign at_smb_base = cfg_addr_i[CFG_AW-1:2] == SMB_BASE_OFF[CFG_AW-1:2];
  assign at_mapped   = at_pm_base || at_smb_base ||
                       cfg_addr_i[CFG_AW-1:2] == PM_EN_OFF[CFG_AW-1:2] ||
                       cfg_addr_i[CFG_AW-1:2] == SMB_EN_OFF[CFG_AW-1:2];

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pm_hit_o && smb_hit_o));

  p_pm_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_hit_o |-> pm_off_o == io_addr_i[PM_ALIGN-1:0]);

  p_smb_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smb_hit_o |-> smb_off_o == io_addr_i[SMB_ALIGN-1:0]);

  p_pm_fixed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_pm_base |-> (cfg_rdata_o[0] && cfg_rdata_o[CFG_DW-1:IO_AW] == '0 &&
                    cfg_rdata_o[PM_ALIGN-1:1] == '0));

  p_smb_fixed_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_smb_base |-> (cfg_rdata_o[0] && cfg_rdata_o[CFG_DW-1:IO_AW] == '0 &&
                     cfg_rdata_o[SMB_ALIGN-1:1] == '0));

  p_unmapped_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_mapped |-> cfg_rdata_o == '0);

endmodule

bind iowin_decode iowin_decode_chk #(
  .IO_AW(IO_AW), .PM_ALIGN(PM_ALIGN), .SMB_ALIGN(SMB_ALIGN),
  .PM_BASE_OFF(PM_BASE_OFF), .PM_EN_OFF(PM_EN_OFF),
  .SMB_BASE_OFF(SMB_BASE_OFF), .SMB_EN_OFF(SMB_EN_OFF)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cfg_addr_i(cfg_addr_i),
  .cfg_rdata_o(cfg_rdata_o), .io_addr_i(io_addr_i),
  .pm_hit_o(pm_hit_o), .pm_off_o(pm_off_o),
  .smb_hit_o(smb_hit_o), .smb_off_o(smb_off_o)
);

// File: tb/sim_iowin_decode.sv
module sim_iowin_decode;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [15:0] io_addr = '0;
  logic        pm_hit, smb_hit;
  logic [6:0]  pm_off;
  logic [3:0]  smb_off;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  iowin_decode u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_be_i(cfg_be), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .io_addr_i(io_addr), .pm_hit_o(pm_hit), .pm_off_o(pm_off),
    .smb_hit_o(smb_hit), .smb_off_o(smb_off)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_be = be; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0; cfg_be = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(req, cfg_rdata, exp);
  endtask

  // Packs {pm_hit, pm_off, smb_hit, smb_off} for comparison.
  task automatic io(input string req, input logic [15:0] a,
                    input logic ph, input logic [6:0] po,
                    input logic sh, input logic [3:0] so);
    @(negedge clk);
    io_addr = a;
    #1;
    chk(req, {18'b0, pm_hit, pm_off, 2'b0, smb_hit, smb_off},
             {18'b0, ph, po, 2'b0, sh, so});
  endtask

  task automatic t_reset;
    rd("R1 pm base reset", 8'h48, 32'h0000_0001);
    rd("R1 smb base reset", 8'h90, 32'h0000_0001);
    rd("R1 pm enable reset", 8'h40, 32'h0);
    rd("R1 smb enable reset", 8'hd0, 32'h0);
    io("R1 no hit at 0", 16'h0000, 1'b0, 7'h00, 1'b0, 4'h0);
  endtask

  task automatic t_pm_base;
    wr(8'h48, 4'hf, 32'hffff_ffff);
    rd("R2 pm base all ones", 8'h48, 32'h0000_ff81);
    wr(8'h48, 4'h2, 32'h1234_5600);
    rd("R4 pm base lane1 only", 8'h48, 32'h0000_5681);
    wr(8'h48, 4'h0, 32'h0000_0000);
    rd("R4 pm base no lanes", 8'h48, 32'h0000_5681);
    wr(8'h48, 4'h1, 32'h0000_0000);
    rd("R4 pm base lane0 clears bit7", 8'h48, 32'h0000_5601);
  endtask

  task automatic t_smb_base;
    wr(8'h90, 4'hf, 32'hffff_ffff);
    rd("R3 smb base all ones", 8'h90, 32'h0000_fff1);
    wr(8'h90, 4'h1, 32'h0000_00a5);
    rd("R4 smb base lane0 only", 8'h90, 32'h0000_ffa1);
  endtask

  task automatic t_enables;
    wr(8'h40, 4'hf, 32'hffff_ffff);
    rd("R5 only byte 0x41 stored", 8'h40, 32'h0000_ff00);
    wr(8'h40, 4'hf, 32'h0);
    wr(8'hd0, 4'h4, 32'h00ff_0000);
    rd("R6 byte 0xd2 keeps low nibble", 8'hd0, 32'h000f_0000);
    wr(8'hd0, 4'h4, 32'h0);
  endtask

  task automatic t_pm_decode;
    wr(8'h48, 4'hf, 32'h0000_1000);
    io("R5 pm closed no hit", 16'h1000, 1'b0, 7'h00, 1'b0, 4'h0);
    wr(8'h40, 4'h2, 32'h0000_8000);
    io("R7 pm first byte", 16'h1000, 1'b1, 7'h00, 1'b0, 4'h0);
    io("R7 pm last byte", 16'h107f, 1'b1, 7'h7f, 1'b0, 4'hf);
    io("R7 pm above window", 16'h1080, 1'b0, 7'h00, 1'b0, 4'h0);
    io("R7 pm below window", 16'h0fff, 1'b0, 7'h7f, 1'b0, 4'hf);
    wr(8'h40, 4'h2, 32'h0000_7f00);
    io("R5 pm bit7 clear no hit", 16'h1000, 1'b0, 7'h00, 1'b0, 4'h0);
  endtask

  task automatic t_smb_decode;
    wr(8'h90, 4'hf, 32'h0000_2000);
    wr(8'hd0, 4'h4, 32'h0001_0000);
    io("R8 smb last byte", 16'h200f, 1'b0, 7'h0f, 1'b1, 4'hf);
    io("R8 smb above window", 16'h2010, 1'b0, 7'h10, 1'b0, 4'h0);
    wr(8'hd0, 4'h4, 32'h00fe_0000);
    rd("R6 upper nibble dropped", 8'hd0, 32'h000e_0000);
    io("R6 smb bit0 clear no hit", 16'h2003, 1'b0, 7'h03, 1'b0, 4'h3);
  endtask

  task automatic t_priority;
    wr(8'h90, 4'hf, 32'h0000_1010);
    wr(8'hd0, 4'h4, 32'h0001_0000);
    wr(8'h48, 4'hf, 32'h0000_1000);
    wr(8'h40, 4'h2, 32'h0000_8000);
    io("R9 overlap pm wins", 16'h1015, 1'b1, 7'h15, 1'b0, 4'h5);
    wr(8'h40, 4'h2, 32'h0);
    io("R9 smb after pm closed", 16'h1015, 1'b0, 7'h15, 1'b1, 4'h5);
  endtask

  task automatic t_unmapped;
    wr(8'h44, 4'hf, 32'hffff_ffff);
    rd("R10 unmapped reads zero", 8'h44, 32'h0);
    rd("R10 pm base untouched", 8'h48, 32'h0000_1001);
    rd("R10 smb base untouched", 8'h90, 32'h0000_1011);
    rd("R10 pm enable untouched", 8'h40, 32'h0);
  endtask

  task automatic t_reset_again;
    @(negedge clk);
    rst_n = 1'b0;
    cfg_addr = 8'h48;
    #1;
    chk("R1 async reset pm base", cfg_rdata, 32'h0000_0001);
    @(negedge clk);
    rst_n = 1'b1;
    rd("R1 smb base after reset", 8'h90, 32'h0000_0001);
    rd("R1 smb enable after reset", 8'hd0, 32'h0);
    io("R1 no hit after reset", 16'h1015, 1'b0, 7'h15, 1'b0, 4'h5);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_pm_base();
    t_smb_base();
    t_enables();
    t_pm_decode();
    t_smb_decode();
    t_priority();
    t_unmapped();
    t_reset_again();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule